// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt and Status Unit

This block sits beside the transmit and receive FIFOs of a serial controller and reduces their occupancy to flags that software and an interrupt controller can use. It counts each FIFO's fill level from the push and pop strobes. It compares each level against a threshold that software can program. It records error events that persist: a transmit push into a full FIFO, a receive push into a full FIFO, and a receive pop from an empty FIFO. From these it produces a raw interrupt vector, a copy of that vector gated by a mask register, one combined interrupt line, and a five-bit status word.

Software clears the error flags through a clear write. One bit of the clear write drops every error flag at once. The other bits each drop a single flag. The threshold registers keep a written value only when it is below the FIFO depth. A driver can therefore find the depth by writing increasing values and reading each one back until the readback no longer matches. The FIFO storage and the bus decoder are outside this block.

Top module: `fifo_irq_status`

## Requirements
- R1: Each FIFO level (0..DEPTH) rises by one on a push and falls by one on a pop, registered on the clock edge. A push and a pop in the same cycle leave the level unchanged, including at full. A push at full with no pop is dropped. A pop at empty is dropped; a push in that same cycle still counts.
- R2: `status_o` bits are: [0] busy = `busy_i` OR transmit level non-zero, [1] transmit level equals DEPTH, [2] transmit level is zero, [3] receive level is zero, [4] receive level equals DEPTH.
- R3: `raw_o[1]` (transmit overflow) is set on the edge of a transmit push at full without a pop, and stays set until cleared.
- R4: `raw_o[2]` (receive underflow) is set by a receive pop at empty. `raw_o[3]` (receive overflow) is set by a receive push at full without a pop. Both stay set until cleared.
- R5: `raw_o[0]` is 1 exactly when the transmit level is less than or equal to the transmit threshold. It follows the live level.
- R6: `raw_o[4]` is 1 exactly when the receive level is greater than or equal to the receive threshold. It follows the live level.
- R7: `masked_o` equals `raw_o` AND the mask register. A mask write takes effect on its clock edge, and the mask resets to all zeros.
- R8: `irq_o` is the OR of `masked_o` delayed by one register stage.
- R9: A clear write decodes as: bit 0 drops all three error flags, bit 1 drops receive underflow, bit 2 drops receive overflow, bit 3 drops transmit overflow. An error event in the same cycle as its clear leaves the flag set.
- R10: A threshold write is stored only when the written value is below DEPTH. Otherwise the register keeps its previous value. Both thresholds reset to DEPTH/2-1.
- R11: After reset both levels are zero, the error flags and the mask are clear, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push_i | input | 1 | Transmit FIFO write strobe |
| tx_pop_i | input | 1 | Transmit FIFO read strobe |
| rx_push_i | input | 1 | Receive FIFO write strobe |
| rx_pop_i | input | 1 | Receive FIFO read strobe |
| busy_i | input | 1 | Serial engine active |
| tx_thr_we_i | input | 1 | Transmit threshold write |
| rx_thr_we_i | input | 1 | Receive threshold write |
| thr_wdata_i | input | WD | Threshold write value |
| mask_we_i | input | 1 | Mask register write |
| mask_wdata_i | input | 5 | Mask write value |
| clr_we_i | input | 1 | Clear write strobe |
| clr_wdata_i | input | 4 | Clear write value |
| raw_o | output | 5 | Unmasked interrupt vector |
| masked_o | output | 5 | Masked interrupt vector |
| irq_o | output | 1 | Combined registered interrupt |
| tx_level_o | output | LVL_W | Transmit fill level |
| rx_level_o | output | LVL_W | Receive fill level |
| status_o | output | 5 | Status word |
| tx_thr_o | output | LVL_W | Transmit threshold readback |
| rx_thr_o | output | LVL_W | Receive threshold readback |

## Verification
The cases that are hardest to reach are the collisions at the extremes of the level. These include a push and a pop together on a full FIFO, and a push and a pop together on an empty one. They also include an error event that lands in the same cycle as the clear bit meant for it. The bench uses a four-entry configuration, so a random walk of push and pop strobes spends much of its time at full and at empty. That walk runs for thousands of cycles, mixed with random clear, mask and threshold writes. Each cycle is compared against an arithmetic model, and directed steps force the collision of an event with its own clear.

// File: rtl/fis_pkg.sv
package fis_pkg;

    localparam int IRQ_W = 5;
    localparam int CLR_W = 4;
    localparam int STA_W = 5;

    // interrupt vector, bit 0 at the bottom
    typedef struct packed {
        logic rx_lvl;   // 4
        logic rx_ovf;   // 3
        logic rx_udf;   // 2
        logic tx_ovf;   // 1
        logic tx_lvl;   // 0
    } irq_bits_t;

    typedef struct packed {
        logic rx_full;  // 4
        logic rx_empty; // 3
        logic tx_empty; // 2
        logic tx_full;  // 1
        logic busy;     // 0
    } stat_bits_t;

    typedef struct packed {
        logic tx_ovf;   // 3
        logic rx_ovf;   // 2
        logic rx_udf;   // 1
        logic all;      // 0
    } clr_bits_t;

    typedef struct packed {
        logic ovf;
        logic udf;
    } fifo_evt_t;

    function automatic logic sticky_next(logic cur, logic set, logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/fis_level_track.sv
module fis_level_track
    import fis_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty,
    output fifo_evt_t        evt
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

    logic [LVL_W-1:0] lvl_q;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (lvl_q == TOP);
    assign empty   = (lvl_q == '0);
    assign pop_ok  = pop & ~empty;
    assign push_ok = push & (~full | pop);

    always_comb begin
        evt.ovf = push & full & ~pop;
        evt.udf = pop & empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   lvl_q <= lvl_q + LVL_W'(1);
                2'b01:   lvl_q <= lvl_q - LVL_W'(1);
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    assign level = lvl_q;
endmodule

// File: rtl/fis_thresh_reg.sv
module fis_thresh_reg #(
    parameter int DEPTH = 16,
    parameter int WD    = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WD-1:0]    wdata,
    output logic [LVL_W-1:0] thr
);
    localparam logic [LVL_W-1:0] RST_VAL = LVL_W'(DEPTH / 2 - 1);

    logic [LVL_W-1:0] thr_q;
    logic             fits;

    assign fits = ({32'd0, wdata} < 64'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= RST_VAL;
        end else if (we && fits) begin
            thr_q <= LVL_W'(wdata);
        end
    end

    assign thr = thr_q;
endmodule

// File: rtl/fis_irq_core.sv
module fis_irq_core
    import fis_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    input  fifo_evt_t        tx_evt,
    input  fifo_evt_t        rx_evt,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_wdata,
    input  logic             clr_we,
    input  logic [CLR_W-1:0] clr_wdata,
    output irq_bits_t        raw,
    output irq_bits_t        masked,
    output logic             irq
);
    clr_bits_t clr;
    irq_bits_t mask_q;
    logic      tx_ovf_q;
    logic      rx_ovf_q;
    logic      rx_udf_q;
    logic      irq_q;

    assign clr = clr_we ? clr_bits_t'(clr_wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
            rx_udf_q <= 1'b0;
        end else begin
            tx_ovf_q <= sticky_next(tx_ovf_q, tx_evt.ovf, clr.all | clr.tx_ovf);
            rx_ovf_q <= sticky_next(rx_ovf_q, rx_evt.ovf, clr.all | clr.rx_ovf);
            rx_udf_q <= sticky_next(rx_udf_q, rx_evt.udf, clr.all | clr.rx_udf);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= irq_bits_t'(mask_wdata);
        end
    end

    always_comb begin
        raw.tx_lvl = (tx_level <= tx_thr);
        raw.tx_ovf = tx_ovf_q;
        raw.rx_udf = rx_udf_q;
        raw.rx_ovf = rx_ovf_q;
        raw.rx_lvl = (rx_level >= rx_thr);
    end

    assign masked = raw & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |masked;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
    import fis_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WD    = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_push_i,
    input  logic             tx_pop_i,
    input  logic             rx_push_i,
    input  logic             rx_pop_i,
    input  logic             busy_i,
    input  logic             tx_thr_we_i,
    input  logic             rx_thr_we_i,
    input  logic [WD-1:0]    thr_wdata_i,
    input  logic             mask_we_i,
    input  logic [4:0]       mask_wdata_i,
    input  logic             clr_we_i,
    input  logic [3:0]       clr_wdata_i,
    output logic [4:0]       raw_o,
    output logic [4:0]       masked_o,
    output logic             irq_o,
    output logic [LVL_W-1:0] tx_level_o,
    output logic [LVL_W-1:0] rx_level_o,
    output logic [4:0]       status_o,
    output logic [LVL_W-1:0] tx_thr_o,
    output logic [LVL_W-1:0] rx_thr_o
);
    localparam int NDIR = 2; // index 0 transmit, 1 receive

    logic [NDIR-1:0]             push_v;
    logic [NDIR-1:0]             pop_v;
    logic [NDIR-1:0]             thr_we_v;
    logic [NDIR-1:0][LVL_W-1:0]  lvl_v;
    logic [NDIR-1:0][LVL_W-1:0]  thr_v;
    logic [NDIR-1:0]             full_v;
    logic [NDIR-1:0]             empty_v;
    fifo_evt_t [NDIR-1:0]        evt_v;

    irq_bits_t  raw_s;
    irq_bits_t  masked_s;
    stat_bits_t stat_s;

    assign push_v   = {rx_push_i, tx_push_i};
    assign pop_v    = {rx_pop_i, tx_pop_i};
    assign thr_we_v = {rx_thr_we_i, tx_thr_we_i};

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        fis_level_track #(
            .DEPTH (DEPTH),
            .LVL_W (LVL_W)
        ) trk_i (
            .clk   (clk),
            .rst   (rst),
            .push  (push_v[g]),
            .pop   (pop_v[g]),
            .level (lvl_v[g]),
            .full  (full_v[g]),
            .empty (empty_v[g]),
            .evt   (evt_v[g])
        );

        fis_thresh_reg #(
            .DEPTH (DEPTH),
            .WD    (WD),
            .LVL_W (LVL_W)
        ) thr_i (
            .clk   (clk),
            .rst   (rst),
            .we    (thr_we_v[g]),
            .wdata (thr_wdata_i),
            .thr   (thr_v[g])
        );
    end

    fis_irq_core #(
        .LVL_W (LVL_W)
    ) core_i (
        .clk        (clk),
        .rst        (rst),
        .tx_level   (lvl_v[0]),
        .rx_level   (lvl_v[1]),
        .tx_thr     (thr_v[0]),
        .rx_thr     (thr_v[1]),
        .tx_evt     (evt_v[0]),
        .rx_evt     (evt_v[1]),
        .mask_we    (mask_we_i),
        .mask_wdata (mask_wdata_i),
        .clr_we     (clr_we_i),
        .clr_wdata  (clr_wdata_i),
        .raw        (raw_s),
        .masked     (masked_s),
        .irq        (irq_o)
    );

    always_comb begin
        stat_s.busy     = busy_i | ~empty_v[0];
        stat_s.tx_full  = full_v[0];
        stat_s.tx_empty = empty_v[0];
        stat_s.rx_empty = empty_v[1];
        stat_s.rx_full  = full_v[1];
    end

    assign raw_o      = raw_s;
    assign masked_o   = masked_s;
    assign status_o   = stat_s;
    assign tx_level_o = lvl_v[0];
    assign rx_level_o = lvl_v[1];
    assign tx_thr_o   = thr_v[0];
    assign rx_thr_o   = thr_v[1];
endmodule

// File: rtl/fis_checker.sv
module fis_checker #(
    parameter int DEPTH = 16,
    parameter int WD    = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_push_i,
    input logic             tx_pop_i,
    input logic             rx_push_i,
    input logic             rx_pop_i,
    input logic             clr_we_i,
    input logic [3:0]       clr_wdata_i,
    input logic [4:0]       raw_o,
    input logic [4:0]       masked_o,
    input logic             irq_o,
    input logic [LVL_W-1:0] tx_level_o,
    input logic [LVL_W-1:0] rx_level_o,
    input logic [LVL_W-1:0] tx_thr_o,
    input logic [LVL_W-1:0] rx_thr_o
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tx_level_o <= TOP) && (rx_level_o <= TOP)); // R1

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (tx_push_i && !tx_pop_i && tx_level_o == TOP) |=> (tx_level_o == TOP)); // R1

    AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (tx_push_i && !tx_pop_i && tx_level_o == TOP) |=> raw_o[1]); // R3

    AST_TX_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (raw_o[1] && !(clr_we_i && (clr_wdata_i[0] || clr_wdata_i[3]))) |=> raw_o[1]); // R3

    AST_RX_UDF_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_pop_i && rx_level_o == '0) |=> raw_o[2]); // R4

    AST_RX_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_push_i && !rx_pop_i && rx_level_o == TOP) |=> raw_o[3]); // R4

    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (masked_o & ~raw_o) == 5'd0); // R7

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        (|masked_o) |=> irq_o); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(|masked_o) |=> !irq_o); // R8

    AST_THR_BELOW_DEPTH: assert property (@(posedge clk) disable iff (rst)
        (tx_thr_o < TOP) && (rx_thr_o < TOP)); // R10
endmodule

bind fifo_irq_status fis_checker #(.DEPTH(DEPTH), .WD(WD), .LVL_W(LVL_W)) chk_i (.*);

// File: tb/fifo_irq_status_tb.sv
module fifo_irq_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int D  = 4;
    localparam int WD = 8;
    localparam int LW = $clog2(D + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, busy = 0;
    logic tx_thr_we = 0, rx_thr_we = 0;
    logic [WD-1:0] thr_wdata = '0;
    logic mask_we = 0;
    logic [4:0] mask_wdata = '0;
    logic clr_we = 0;
    logic [3:0] clr_wdata = '0;
    logic [4:0] raw, masked, status;
    logic irq;
    logic [LW-1:0] tx_level, rx_level, tx_thr, rx_thr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    int m_tl, m_rl, m_tt, m_rt;
    bit m_tov, m_rov, m_rud;
    logic [4:0] m_mask;
    bit m_irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fifo_irq_status #(.DEPTH(D), .WD(WD)) dut_i (
        .clk(clk), .rst(rst),
        .tx_push_i(tx_push), .tx_pop_i(tx_pop),
        .rx_push_i(rx_push), .rx_pop_i(rx_pop),
        .busy_i(busy),
        .tx_thr_we_i(tx_thr_we), .rx_thr_we_i(rx_thr_we), .thr_wdata_i(thr_wdata),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
        .clr_we_i(clr_we), .clr_wdata_i(clr_wdata),
        .raw_o(raw), .masked_o(masked), .irq_o(irq),
        .tx_level_o(tx_level), .rx_level_o(rx_level),
        .status_o(status), .tx_thr_o(tx_thr), .rx_thr_o(rx_thr)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] exp_raw();
        logic [4:0] r;
        r[0] = (m_tl <= m_tt);
        r[1] = m_tov;
        r[2] = m_rud;
        r[3] = m_rov;
        r[4] = (m_rl >= m_rt);
        return r;
    endfunction

    function automatic logic [4:0] exp_stat();
        logic [4:0] s;
        s[0] = busy | (m_tl != 0);
        s[1] = (m_tl == D);
        s[2] = (m_tl == 0);
        s[3] = (m_rl == 0);
        s[4] = (m_rl == D);
        return s;
    endfunction

    task automatic check_all();
        logic [4:0] er;
        er = exp_raw();
        chk("R1 tx level", int'(tx_level), m_tl);
        chk("R1 rx level", int'(rx_level), m_rl);
        chk("R2 status", int'(status), int'(exp_stat()));
        chk("R3 tx overflow", int'(raw[1]), int'(er[1]));
        chk("R4 rx error flags", int'(raw[3:2]), int'(er[3:2]));
        chk("R5 tx level irq", int'(raw[0]), int'(er[0]));
        chk("R6 rx level irq", int'(raw[4]), int'(er[4]));
        chk("R7 masked", int'(masked), int'(er & m_mask));
        chk("R8 irq", int'(irq), int'(m_irq));
        chk("R10 tx thr", int'(tx_thr), m_tt);
        chk("R10 rx thr", int'(rx_thr), m_rt);
    endtask

    task automatic model_fifo(inout int lvl, input bit pu, input bit po,
                              output bit ovf, output bit udf);
        bit pop_ok, push_ok;
        pop_ok  = po && (lvl > 0);
        push_ok = pu && (lvl < D || po);
        ovf = pu && (lvl == D) && !po;
        udf = po && (lvl == 0);
        lvl = lvl + int'(push_ok) - int'(pop_ok);
    endtask

    // one clock with the given strobes; model updated alongside
    task automatic step(bit tpu, bit tpo, bit rpu, bit rpo,
                        bit cwe, logic [3:0] cw,
                        bit mwe, logic [4:0] mw,
                        bit twe, bit rwe, logic [WD-1:0] tw);
        bit tov_e, tud_e, rov_e, rud_e;
        bit c_all;
        m_irq = |(exp_raw() & m_mask);
        tx_push = tpu; tx_pop = tpo; rx_push = rpu; rx_pop = rpo;
        clr_we = cwe; clr_wdata = cw;
        mask_we = mwe; mask_wdata = mw;
        tx_thr_we = twe; rx_thr_we = rwe; thr_wdata = tw;
        model_fifo(m_tl, tpu, tpo, tov_e, tud_e);
        model_fifo(m_rl, rpu, rpo, rov_e, rud_e);
        c_all = cwe && cw[0];
        m_tov = tov_e || (m_tov && !(c_all || (cwe && cw[3])));
        m_rov = rov_e || (m_rov && !(c_all || (cwe && cw[2])));
        m_rud = rud_e || (m_rud && !(c_all || (cwe && cw[1])));
        if (mwe) m_mask = mw;
        if (twe && tw < D) m_tt = int'(tw);
        if (rwe && tw < D) m_rt = int'(tw);
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        clr_we = 0; mask_we = 0; tx_thr_we = 0; rx_thr_we = 0;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 4'h0, 0, 5'h0, 0, 0, '0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] seed;
        m_tl = 0; m_rl = 0; m_tt = D / 2 - 1; m_rt = D / 2 - 1;
        m_tov = 0; m_rov = 0; m_rud = 0; m_mask = '0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk("R11 tx level", int'(tx_level), 0);
        chk("R11 rx level", int'(rx_level), 0);
        chk("R11 raw", int'(raw), 5'b00001);
        chk("R11 masked", int'(masked), 0);
        chk("R11 irq", int'(irq), 0);
        chk("R11 status", int'(status), 5'b01100);
        chk("R10 reset thr", int'(tx_thr), D / 2 - 1);

        // R10 threshold retention sweep, both registers
        for (int v = 0; v < 12; v++) begin
            step(0, 0, 0, 0, 0, 4'h0, 0, 5'h0, 1, 0, WD'(v));
            chk("R10 tx readback", int'(tx_thr), m_tt);
            step(0, 0, 0, 0, 0, 4'h0, 0, 5'h0, 0, 1, WD'(11 - v));
            chk("R10 rx readback", int'(rx_thr), m_rt);
        end
        step(0, 0, 0, 0, 0, 4'h0, 0, 5'h0, 1, 1, WD'(200));
        chk("R10 large value ignored", int'(tx_thr), m_tt);

        // R5 / R6 sweep of every threshold against every level
        for (int t = 0; t < D; t++) begin
            step(0, 0, 0, 0, 0, 4'h0, 0, 5'h0, 1, 1, WD'(t));
            for (int l = 0; l <= D; l++) begin
                check_all();
                if (l < D) step(1, 0, 1, 0, 0, 4'h0, 0, 5'h0, 0, 0, '0);
            end
            for (int l = 0; l < D; l++) begin
                step(0, 1, 0, 1, 0, 4'h0, 0, 5'h0, 0, 0, '0);
                check_all();
            end
        end

        // R1 collisions at full and empty
        repeat (D) step(1, 0, 1, 0, 0, 4'h0, 0, 5'h0, 0, 0, '0);
        step(1, 1, 1, 1, 0, 4'h0, 0, 5'h0, 0, 0, '0);
        chk("R1 push+pop at full", int'(tx_level), D);
        chk("R3 no overflow on push+pop at full", int'(raw[1]), 0);
        // R3 overflow, selective clear that misses, then the right bit
        step(1, 0, 0, 0, 0, 4'h0, 0, 5'h0, 0, 0, '0);
        chk("R3 overflow set", int'(raw[1]), 1);
        chk("R1 push at full dropped", int'(tx_level), D);
        step(0, 0, 0, 0, 1, 4'b0110, 0, 5'h0, 0, 0, '0);
        chk("R9 wrong bits keep tx overflow", int'(raw[1]), 1);
        step(0, 0, 0, 0, 1, 4'b1000, 0, 5'h0, 0, 0, '0);
        chk("R9 bit3 clears tx overflow", int'(raw[1]), 0);
        // R9 event and its clear in the same cycle
        step(1, 0, 0, 0, 1, 4'b1001, 0, 5'h0, 0, 0, '0);
        chk("R9 set wins over clear", int'(raw[1]), 1);
        // R4 rx overflow
        step(0, 0, 1, 0, 0, 4'h0, 0, 5'h0, 0, 0, '0);
        chk("R4 rx overflow", int'(raw[3]), 1);
        repeat (D) step(0, 1, 0, 1, 0, 4'h0, 0, 5'h0, 0, 0, '0);
        step(0, 0, 1, 1, 0, 4'h0, 0, 5'h0, 0, 0, '0);
        chk("R1 push+pop at empty counts push", int'(rx_level), 1);
        chk("R4 rx underflow", int'(raw[2]), 1);
        step(0, 0, 0, 0, 1, 4'b0010, 0, 5'h0, 0, 0, '0);
        chk("R9 bit1 clears only underflow", int'(raw[3:1]), 3'b101);
        step(0, 0, 0, 0, 1, 4'b0001, 0, 5'h0, 0, 0, '0);
        chk("R9 bit0 clears all", int'(raw[3:1]), 0);

        // R8 latency
        step(0, 0, 0, 0, 0, 4'h0, 1, 5'b00010, 0, 0, '0);
        step(1, 1, 0, 0, 0, 4'h0, 0, 5'h0, 0, 0, '0);
        check_all();
        step(0, 0, 0, 0, 0, 4'h0, 0, 5'h0, 0, 0, '0);
        check_all();

        // R7 all mask values against the current raw vector
        for (int m = 0; m < 32; m++) begin
            step(0, 0, 0, 0, 0, 4'h0, 1, 5'(m), 0, 0, '0);
            check_all();
        end

        // random walk, every cycle compared
        seed = 32'h1d2c3b4a;
        for (int i = 0; i < 4000; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            busy = seed[30];
            step(seed[16], seed[17], seed[18], seed[19],
                 seed[22:20] == 3'd0, seed[26:23],
                 seed[29:27] == 3'd0, seed[12:8],
                 seed[5:2] == 4'd0, seed[5:2] == 4'd1, WD'(seed[15:13]));
            check_all();
        end
        idle();
        check_all();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule